// File: doc/BRIEF.md
# Multi-lane PRBS memory data generator

This block produces one 32-bit data word per step for memory stress testing. Each bit lane of the word comes from its own Fibonacci shift register, and all lanes share one feedback polynomial chosen by an order select (7, 15, 23 or 31). One lane, the victim, always starts from a fixed seed tied to the order. The other lanes either start from that same seed or from per-lane seed bits supplied on an input bus, so the victim can be exercised with either identical or unrelated neighbours.

A run has two phases of equal length, 2^n − 1 steps each. The second phase continues the same register sequence without reseeding, but the victim bit is inverted in every emitted word. In generate mode the words leave on a valid/ready output, and the registers advance only when a word is accepted. In compare mode nothing is emitted. Each word read back from memory is compared against the regenerated expected word, and a mismatch is reported with its step index and both words.

Top module: `prbs_lane_gen`

## Requirements
- R1: After reset, busy, done, out_valid, cfg_err and mis_err are all low.
- R2: cfg_order selects the order: 0 selects n=7, 1 selects n=15, 2 selects n=23 and 3 selects n=31. The output bit stream x of every lane obeys x[m] = x[m−n] XOR x[m−t] for m ≥ n, where t is 3, 1, 5 and 3 for the four orders in that sequence.
- R3: The fixed seeds, written as the first n emitted bits from left to right, are 1111101 for order 7, 111110101101110 for order 15, 11111010110111001011101 for order 23 and 1111101011011100101110100010011 for order 31. The victim lane always loads the fixed seed. With cfg_random low, every lane loads it.
- R4: With cfg_random high, each non-victim lane j loads bits lane_seed[j*31 + n−1 : j*31]. Bit j*31 + n−1 is emitted first.
- R5: Bit j of the data word is produced by lane j.
- R6: Each phase lasts 2^n − 1 accepted steps. The phase output is 0 in the first phase and 1 in the second. The second phase continues the lane sequences without reseeding and inverts only the victim bit.
- R7: A start with cfg_victim ≥ 32 starts no run, and cfg_err pulses high in the following cycle.
- R8: In generate mode a word is accepted when out_valid and out_ready are both high. While out_ready is low, out_data is held and no lane advances.
- R9: On the edge that accepts the last step of the second phase, busy falls and done rises. Done falls when the next run is accepted.
- R10: A start while busy is ignored: the running sequence and its configuration continue unchanged, and cfg_err stays low.
- R11: In compare mode out_valid stays low, and each cycle with rd_valid high compares rd_data against the expected word and advances one step. On a mismatch, mis_err pulses in the next cycle with mis_step (the step index within the run, counting from 0), mis_exp and mis_act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a run using the cfg_* inputs |
| cfg_order | input | 2 | Order select (0:7, 1:15, 2:23, 3:31) |
| cfg_victim | input | 6 | Victim lane index |
| cfg_random | input | 1 | Non-victim lanes take seeds from lane_seed |
| cfg_check | input | 1 | Compare mode instead of generate mode |
| lane_seed | input | 992 | 31 seed bits per lane, lane j at j*31 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished both phases |
| phase | output | 1 | 0 in the first phase, 1 in the inverted phase |
| cfg_err | output | 1 | One-cycle pulse for a rejected start |
| out_valid | output | 1 | Generated word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Generated word |
| rd_valid | input | 1 | Read-back word present (compare mode) |
| rd_data | input | 32 | Read-back word |
| mis_err | output | 1 | One-cycle mismatch pulse |
| mis_step | output | 32 | Step index of the last mismatch |
| mis_exp | output | 32 | Expected word of the last mismatch |
| mis_act | output | 32 | Read word of the last mismatch |

## Verification
Full order-7 runs are tried with all lanes on the fixed seed and with distinct per-lane seeds. The first tells the tap and seed wiring apart, and the second also separates lane-to-bit mapping and the victim seed mux. A full order-15 run with the victim on the top lane checks the phase length and the inversion at the widest lane index. Partial order-23 and order-31 runs check their taps and seeds. A stalling ready pattern with a start pulse mid-run separates correct hold and ignore behaviour from advancing on a stall. A compare run with gap cycles and errors injected in both phases checks the pulse timing and the reported step and words.

// File: rtl/prbs_gen_pkg.sv
// Shared order encoding and per-order constants for the PRBS lane generator.
// Assumes shift registers are LFSR_W bits wide, with the oldest bit at index n-1.
package prbs_gen_pkg;

    localparam int LFSR_W = 31;
    localparam logic [4:0] TOP_IDX = 5'(LFSR_W - 1);

    typedef enum logic [1:0] {
        ORD_7  = 2'd0,
        ORD_15 = 2'd1,
        ORD_23 = 2'd2,
        ORD_31 = 2'd3
    } prbs_ord_e;

    // Index of the oldest stored bit (n-1), which is also the emitted bit.
    function automatic logic [4:0] ord_msb(input prbs_ord_e o);
        case (o)
            ORD_7:   return 5'd6;
            ORD_15:  return 5'd14;
            ORD_23:  return 5'd22;
            default: return 5'd30;
        endcase
    endfunction

    // Index of the second feedback tap (t-1).
    function automatic logic [4:0] ord_tap_idx(input prbs_ord_e o);
        case (o)
            ORD_7:   return 5'd2;
            ORD_15:  return 5'd0;
            ORD_23:  return 5'd4;
            default: return 5'd2;
        endcase
    endfunction

    // Fixed seed, right aligned; the leftmost written bit is emitted first.
    function automatic logic [LFSR_W-1:0] ord_seed(input prbs_ord_e o);
        case (o)
            ORD_7:   return LFSR_W'(7'b1111101);
            ORD_15:  return LFSR_W'(15'b111110101101110);
            ORD_23:  return LFSR_W'(23'b11111010110111001011101);
            default: return LFSR_W'(31'b1111101011011100101110100010011);
        endcase
    endfunction

    // Phase length 2^n - 1 as an all-ones value of n bits.
    function automatic logic [LFSR_W-1:0] ord_span(input prbs_ord_e o);
        return {LFSR_W{1'b1}} >> (TOP_IDX - ord_msb(o));
    endfunction

endpackage

// File: rtl/prbs_lane.sv
// One bit lane: a Fibonacci shift register whose length and taps follow the
// selected order. The emitted bit is the oldest stored bit. Bits above n-1
// are never read, so the register keeps one fixed width for every order.
module prbs_lane
    import prbs_gen_pkg::*;
#(
    parameter int W = LFSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  prbs_ord_e    ord,
    input  logic [W-1:0] seed,
    output logic         bit_o
);

    logic [W-1:0] sr;
    logic         head;
    logic         fb;

    // Select the emitted bit and form the two-tap feedback.
    always_comb begin
        head  = sr[ord_msb(ord)];
        fb    = head ^ sr[ord_tap_idx(ord)];
        bit_o = head;
    end

    // Load the seed at start, otherwise shift one step per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= seed;
        end else if (adv) begin
            sr <= {sr[W-2:0], fb};
        end
    end

endmodule

// File: rtl/prbs_seq_ctrl.sv
// Run sequencer: accepts or rejects a start, latches the configuration,
// counts steps through the two phases and decides when the lanes advance.
// Assumes the lanes load in the same cycle that load is high.
module prbs_seq_ctrl
    import prbs_gen_pkg::*;
#(
    parameter int LANES = 32,
    parameter int VW    = $clog2(LANES) + 1,
    parameter int IDXW  = LFSR_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  prbs_ord_e       cfg_order,
    input  logic [VW-1:0]   cfg_victim,
    input  logic            cfg_check,
    input  logic            out_ready,
    input  logic            rd_valid,
    output logic            load,
    output logic            adv,
    output logic            busy,
    output logic            done,
    output logic            phase,
    output logic            cfg_err,
    output logic            out_valid,
    output logic            chk_en,
    output prbs_ord_e       ord_q,
    output logic [VW-1:0]   victim_q,
    output logic [IDXW-1:0] run_idx
);

    localparam logic [VW-1:0] LANE_LIM = VW'(LANES);

    logic              check_q;
    logic              victim_ok;
    logic [LFSR_W-1:0] cnt;
    logic [LFSR_W-1:0] last;

    // Decode start acceptance and the per-cycle advance condition.
    always_comb begin
        victim_ok = cfg_victim < LANE_LIM;
        load      = start && !busy && victim_ok;
        out_valid = busy && !check_q;
        chk_en    = busy && check_q && rd_valid;
        adv       = (out_valid && out_ready) || chk_en;
        last      = ord_span(ord_q) - LFSR_W'(1);
    end

    // Run state: configuration latch, phase and step counters, done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            phase    <= 1'b0;
            cfg_err  <= 1'b0;
            check_q  <= 1'b0;
            ord_q    <= ORD_7;
            victim_q <= '0;
            cnt      <= '0;
            run_idx  <= '0;
        end else begin
            cfg_err <= start && !busy && !victim_ok;
            if (load) begin
                busy     <= 1'b1;
                done     <= 1'b0;
                phase    <= 1'b0;
                check_q  <= cfg_check;
                ord_q    <= cfg_order;
                victim_q <= cfg_victim;
                cnt      <= '0;
                run_idx  <= '0;
            end else if (adv) begin
                run_idx <= run_idx + IDXW'(1);
                if (cnt == last) begin
                    cnt <= '0;
                    if (phase) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        phase <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + LFSR_W'(1);
                end
            end
        end
    end

    // R9: a finished run is never also running.
    a_r9_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: a rejected start leaves the block idle.
    a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    // R10: the latched configuration does not move while a run continues.
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ord_q) && $stable(victim_q)));

endmodule

// File: rtl/prbs_cmp.sv
// Read-back checker: compares a read word with the regenerated word and
// registers a one-cycle error pulse with the step index and both words.
// Assumes en is high only in cycles where the expected word is current.
module prbs_cmp #(
    parameter int LANES = 32,
    parameter int IDXW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LANES-1:0] exp_w,
    input  logic [LANES-1:0] act_w,
    input  logic [IDXW-1:0]  idx,
    output logic             mis_err,
    output logic [IDXW-1:0]  mis_step,
    output logic [LANES-1:0] mis_exp,
    output logic [LANES-1:0] mis_act
);

    logic diff;

    // Detect a mismatch in a checked cycle.
    always_comb diff = en && (exp_w != act_w);

    // Pulse the error and hold the details of the latest mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_err  <= 1'b0;
            mis_step <= '0;
            mis_exp  <= '0;
            mis_act  <= '0;
        end else begin
            mis_err <= diff;
            if (diff) begin
                mis_step <= idx;
                mis_exp  <= exp_w;
                mis_act  <= act_w;
            end
        end
    end

    // R11: a reported mismatch always carries two different words.
    a_r11_err_differs: assert property (@(posedge clk) disable iff (!rst_n)
        mis_err |-> (mis_exp != mis_act));

endmodule

// File: rtl/prbs_lane_gen.sv
// Multi-lane PRBS data generator and checker. Each lane runs its own shift
// register. The victim lane is seeded from the fixed per-order seed, and the
// others are seeded from it or from lane_seed. Bit j of the word is lane j,
// with the victim bit inverted during the second phase.
module prbs_lane_gen
    import prbs_gen_pkg::*;
#(
    parameter int LANES = 32,
    parameter int W     = LFSR_W,
    parameter int VW    = $clog2(LANES) + 1,
    parameter int IDXW  = W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       cfg_order,
    input  logic [VW-1:0]    cfg_victim,
    input  logic             cfg_random,
    input  logic             cfg_check,
    input  logic [LANES*W-1:0] lane_seed,
    output logic             busy,
    output logic             done,
    output logic             phase,
    output logic             cfg_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LANES-1:0] out_data,
    input  logic             rd_valid,
    input  logic [LANES-1:0] rd_data,
    output logic             mis_err,
    output logic [IDXW-1:0]  mis_step,
    output logic [LANES-1:0] mis_exp,
    output logic [LANES-1:0] mis_act
);

    prbs_ord_e        ord_in;
    prbs_ord_e        ord_q;
    logic [VW-1:0]    victim_q;
    logic [IDXW-1:0]  run_idx;
    logic             load;
    logic             adv;
    logic             chk_en;
    logic [LANES-1:0] lane_bit;
    logic [LANES-1:0] word;

    // Cast the raw order code to the shared enum.
    always_comb ord_in = prbs_ord_e'(cfg_order);

    prbs_seq_ctrl #(
        .LANES (LANES),
        .VW    (VW),
        .IDXW  (IDXW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_order  (ord_in),
        .cfg_victim (cfg_victim),
        .cfg_check  (cfg_check),
        .out_ready  (out_ready),
        .rd_valid   (rd_valid),
        .load       (load),
        .adv        (adv),
        .busy       (busy),
        .done       (done),
        .phase      (phase),
        .cfg_err    (cfg_err),
        .out_valid  (out_valid),
        .chk_en     (chk_en),
        .ord_q      (ord_q),
        .victim_q   (victim_q),
        .run_idx    (run_idx)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [W-1:0] sd;

        // Pick the seed: external bits for aggressors in random mode, else fixed.
        always_comb begin
            if (cfg_random && (cfg_victim != VW'(j)))
                sd = lane_seed[j*W +: W];
            else
                sd = ord_seed(ord_in);
        end

        prbs_lane #(
            .W (W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .adv   (adv),
            .ord   (ord_q),
            .seed  (sd),
            .bit_o (lane_bit[j])
        );

        // Place the lane bit, inverting the victim in the second phase.
        always_comb word[j] = lane_bit[j] ^ (phase && (victim_q == VW'(j)));
    end

    // Present the generated word on the output.
    always_comb out_data = word;

    prbs_cmp #(
        .LANES (LANES),
        .IDXW  (IDXW)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (chk_en),
        .exp_w    (word),
        .act_w    (rd_data),
        .idx      (run_idx),
        .mis_err  (mis_err),
        .mis_step (mis_step),
        .mis_exp  (mis_exp),
        .mis_act  (mis_act)
    );

    // R8: a stalled word stays valid and unchanged.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/prbs_lane_gen_tb_top.sv
// Directed bench: one task per scenario, each checking its own results
// against a bench-side recurrence model of every lane.
module prbs_lane_gen_tb_top;

    localparam int LANES = 32;
    localparam int W     = 31;
    localparam int VW    = 6;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start;
    logic [1:0]         cfg_order;
    logic [VW-1:0]      cfg_victim;
    logic               cfg_random;
    logic               cfg_check;
    logic [LANES*W-1:0] lane_seed;
    logic               busy, done, phase, cfg_err, out_valid, out_ready;
    logic [LANES-1:0]   out_data;
    logic               rd_valid;
    logic [LANES-1:0]   rd_data;
    logic               mis_err;
    logic [31:0]        mis_step;
    logic [LANES-1:0]   mis_exp, mis_act;

    always #4 clk = ~clk;

    prbs_lane_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_order(cfg_order),
        .cfg_victim(cfg_victim), .cfg_random(cfg_random), .cfg_check(cfg_check),
        .lane_seed(lane_seed), .busy(busy), .done(done), .phase(phase),
        .cfg_err(cfg_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .mis_err(mis_err), .mis_step(mis_step), .mis_exp(mis_exp), .mis_act(mis_act)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic   hist [0:LANES-1][0:31];
    int     m_n, m_t, m_v;
    longint m_len, m_m;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [30:0] fixed_seed(input int o);
        case (o)
            0:       return 31'(7'b1111101);
            1:       return 31'(15'b111110101101110);
            2:       return 31'(23'b11111010110111001011101);
            default: return 31'b1111101011011100101110100010011;
        endcase
    endfunction

    task automatic model_init(input int o, input bit rnd, input int v);
        logic [30:0] sd;
        case (o)
            0:       begin m_n = 7;  m_t = 3; end
            1:       begin m_n = 15; m_t = 1; end
            2:       begin m_n = 23; m_t = 5; end
            default: begin m_n = 31; m_t = 3; end
        endcase
        m_len = (64'd1 << m_n) - 1;
        m_v   = v;
        m_m   = 0;
        for (int j = 0; j < LANES; j++) begin
            sd = (rnd && j != v) ? lane_seed[j*W +: W] : fixed_seed(o);
            for (int i = 0; i < m_n; i++) hist[j][i] = sd[m_n-1-i];
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w;
        for (int j = 0; j < LANES; j++)
            w[j] = hist[j][int'(m_m % 32)] ^ ((m_m >= m_len) && (j == m_v));
        return w;
    endfunction

    task automatic model_adv();
        m_m++;
        if (m_m >= m_n)
            for (int j = 0; j < LANES; j++)
                hist[j][int'(m_m % 32)] = hist[j][int'((m_m - m_n) % 32)] ^
                                          hist[j][int'((m_m - m_t) % 32)];
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_start(input int o, input int v, input bit rnd, input bit cm);
        cfg_order = 2'(o); cfg_victim = VW'(v); cfg_random = rnd; cfg_check = cm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Generate mode: accept words (optionally stalling), compare with the model.
    task automatic run_gen(input int total, input bit stall, input int kick, input bit full, input string tag);
        int acc = 0;
        int cyc = 0;
        logic [31:0] w;
        while (acc < total) begin
            out_ready = !(stall && (cyc % 3 == 1));
            start = (kick > 0 && cyc == kick);
            if (start) begin
                cfg_order = 2'd1; cfg_victim = 6'd40; cfg_random = ~cfg_random;
            end
            w = exp_word();
            chk(out_valid === 1'b1 && out_data === w, tag, 64'(out_data), 64'(w));
            if (m_m == m_len - 1 || m_m == m_len)
                chk(phase === (m_m >= m_len), "R6 phase flag at boundary", 64'(phase), 64'(m_m >= m_len));
            if (kick > 0 && cyc == kick + 1)
                chk(cfg_err === 1'b0 && busy === 1'b1, "R10 start while busy ignored", 64'(cfg_err), 64'd0);
            @(negedge clk);
            if (out_ready) begin
                acc++;
                model_adv();
            end
            cyc++;
        end
        start = 1'b0;
        out_ready = 1'b0;
        if (full) begin
            chk(done === 1'b1 && busy === 1'b0, "R9 done after both phases", {busy, done}, 64'b01);
            chk(out_valid === 1'b0, "R8 no valid after run", 64'(out_valid), 64'd0);
        end else begin
            chk(done === 1'b0 && busy === 1'b1, "R6 run still in first phase", {busy, done}, 64'b10);
        end
    endtask

    task automatic t_reset();
        apply_reset();
        chk(busy === 0 && done === 0 && out_valid === 0 && cfg_err === 0 && mis_err === 0,
            "R1 reset state", {busy, done, out_valid, cfg_err, mis_err}, 64'd0);
    endtask

    task automatic t_bad_victim(input int v);
        do_start(0, v, 0, 0);
        chk(cfg_err === 1'b1 && busy === 1'b0, "R7 bad victim pulse", {cfg_err, busy}, 64'b10);
        @(negedge clk);
        chk(cfg_err === 1'b0 && busy === 1'b0 && out_valid === 1'b0, "R7 pulse single, no run",
            {cfg_err, busy, out_valid}, 64'd0);
    endtask

    task automatic t_fixed7();
        model_init(0, 0, 0);
        do_start(0, 0, 0, 0);
        chk(busy === 1'b1 && done === 1'b0, "R9 run accepted", {busy, done}, 64'b10);
        run_gen(254, 0, 0, 1, "R2 R3 R5 order7 all fixed seed");
    endtask

    task automatic t_rand7_stall();
        model_init(0, 1, 5);
        do_start(0, 5, 1, 0);
        chk(done === 1'b0, "R9 done clears on new run", 64'(done), 64'd0);
        run_gen(254, 1, 20, 1, "R4 R8 R10 order7 random seeds with stalls");
    endtask

    // Compare mode with gap cycles and errors injected in both phases.
    task automatic t_cmp7();
        int acc = 0;
        int cyc = 0;
        bit gap, bad;
        logic [31:0] w, a;
        model_init(0, 1, 9);
        do_start(0, 9, 1, 1);
        while (acc < 254) begin
            gap = (cyc % 5 == 2);
            w = exp_word();
            a = (m_m == 3 || m_m == 200) ? (w ^ (32'd1 << (m_m % 32))) : w;
            rd_valid = !gap;
            rd_data  = a;
            if (cyc == 0) chk(out_valid === 1'b0, "R11 no output in compare mode", 64'(out_valid), 64'd0);
            @(negedge clk);
            bad = !gap && (w != a);
            chk(mis_err === bad, "R11 mismatch pulse", 64'(mis_err), 64'(bad));
            if (bad) begin
                chk(64'(mis_step) == m_m, "R11 step index", 64'(mis_step), 64'(m_m));
                chk(mis_exp === w, "R11 expected word", 64'(mis_exp), 64'(w));
                chk(mis_act === a, "R11 actual word", 64'(mis_act), 64'(a));
            end
            if (!gap) begin
                acc++;
                model_adv();
            end
            cyc++;
        end
        rd_valid = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R9 compare run completes", {busy, done}, 64'b01);
    endtask

    task automatic t_rand15();
        model_init(1, 1, 31);
        do_start(1, 31, 1, 0);
        run_gen(65534, 0, 0, 1, "R2 R4 R6 order15 victim lane 31");
    endtask

    task automatic t_part(input int o, input int v, input bit rnd, input int n, input string tag);
        model_init(o, rnd, v);
        do_start(o, v, rnd, 0);
        run_gen(n, 0, 0, 0, tag);
        apply_reset();
        chk(busy === 1'b0 && out_valid === 1'b0, "R1 reset ends run", {busy, out_valid}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; cfg_order = '0; cfg_victim = '0;
        cfg_random = 1'b0; cfg_check = 1'b0; out_ready = 1'b0;
        rd_valid = 1'b0; rd_data = '0;
        for (int j = 0; j < LANES; j++)
            lane_seed[j*W +: W] = 31'((j + 1) * 32'h9E37_79B1 ^ (j * 32'h0101_0F0F));
        t_reset();
        t_bad_victim(32);
        t_bad_victim(63);
        t_fixed7();
        t_rand7_stall();
        t_cmp7();
        t_rand15();
        t_part(2, 17, 1, 300, "R2 R3 R4 order23 partial");
        t_part(3, 0, 0, 100, "R2 R3 order31 partial all fixed");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule